// File: doc/BRIEF.md
# Unaligned Burst Write Strobe Generator

This block sits on the issuing side of a 32-bit write channel and produces the byte-lane enable word for every beat of an incrementing burst. It takes one command through a valid/ready handshake. The command carries the low bits of the start address, a transfer-size code and a beat count. The block then presents one strobe word and a final-beat flag per beat through a second valid/ready handshake. A receiver can pick out the valid byte lanes from the strobe word alone, without decoding any address bits.

When the start address is not aligned to the transfer size, the first beat clears every lane below the start offset. Every later beat lands on a size boundary and enables the whole size window. For transfers narrower than the bus, that window moves across the lanes from beat to beat and wraps back to lane 0 after the top lane. The block has two named states. In `ST_IDLE` it waits for a command, and it moves to `ST_BEAT` when a command is accepted. In `ST_BEAT` it offers beats, and it returns to `ST_IDLE` when the final beat is accepted. Any other accepted beat keeps it in `ST_BEAT` and advances it to the next beat.

Top module: `wstrb_burst_gen`

## Requirements
- R1: After reset is released, cmd_ready is 1, beat_valid is 0 and beat_last is 0.
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both 1. From the next cycle, beat_valid is 1 and cmd_ready is 0.
- R3: On the first beat, the strobe enables only the lanes that satisfy both conditions below. Size code 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. Example: offset 1 with size code 2 gives 4'b1110.
    - The lane lies in the size window that starts at the start offset rounded down to the size.
    - The lane index is at least the start offset.
- R4: Every beat after the first enables the full size window. Each window begins where the previous one ended and wraps modulo 4 lanes. Example: 1-byte beats from offset 3 give 4'b1000, then 4'b0001, then 4'b0010.
- R5: A burst has cmd_len + 1 beats. beat_last is 1 on the final beat only.
- R6: cmd_ready stays 0 for the whole burst, and a command presented during a burst has no effect. cmd_ready returns to 1 in the cycle after the final beat is accepted.
- R7: While beat_valid is 1 and beat_ready is 0, beat_strb and beat_last keep their values.
- R8: Size codes above 2 are treated as 4-byte transfers.
- R9: The strobe word is never zero on a valid beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_addr_lo | input | 2 | Low start-address bits (lane offset) |
| cmd_size | input | 3 | Transfer size code, bytes = 2^code, clamped to bus width |
| cmd_len | input | 8 | Number of beats minus one |
| beat_valid | output | 1 | Beat strobe offered |
| beat_ready | input | 1 | Beat taken by the consumer |
| beat_strb | output | 4 | Byte-lane enables for this beat |
| beat_last | output | 1 | Final beat of the burst |

## Verification
The assertions check the following on every cycle:
- The strobe and final flag hold steady during a stall.
- No valid beat has a zero strobe.
- The first beat never enables a lane below the accepted offset.
- Every later beat carries exactly as many enables as the size allows.
- Acceptance of the final beat hands control back to the command side.

Only the bench's sweep can show that the window sits at the right lane positions and wraps correctly. It sweeps every offset against each size code, including codes above 2, and bursts of one to six beats. The same sweep also shows that the beat count matches the command, and that a command held during a burst leaves that burst and the next one unchanged.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BEAT = 1'b1
    } wsg_state_e;
endpackage

// File: rtl/wsg_lane_mask.sv
// Combinational byte-lane enable for one beat.
module wsg_lane_mask #(
    parameter int BUS_BYTES = 4,
    parameter int OFF_W     = $clog2(BUS_BYTES),
    parameter int SZ_W      = 3
) (
    input  logic [OFF_W-1:0]     offset,
    input  logic [SZ_W-1:0]      size_log,
    input  logic                 first,
    output logic [BUS_BYTES-1:0] strb
);
    localparam int IW = OFF_W + 1;

    logic [IW-1:0] win_bytes;
    logic [IW-1:0] win_base;
    logic [IW-1:0] win_end;
    logic [IW-1:0] off_w;

    always_comb begin
        off_w     = {1'b0, offset};
        win_bytes = IW'(1) << size_log;
        win_base  = off_w & ~(win_bytes - IW'(1));
        win_end   = win_base + win_bytes;
    end

    for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
        localparam logic [IW-1:0] LANE = IW'(g);
        assign strb[g] = (LANE >= win_base) && (LANE < win_end)
                       && (!first || (LANE >= off_w));
    end
endmodule

// File: rtl/wsg_track.sv
// Per-burst position tracking: lane offset, remaining beats, first-beat flag.
module wsg_track #(
    parameter int OFF_W = 2,
    parameter int SZ_W  = 3,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [OFF_W-1:0] ld_offset,
    input  logic [SZ_W-1:0]  ld_size_log,
    input  logic [LEN_W-1:0] ld_len,
    output logic [OFF_W-1:0] offset,
    output logic [SZ_W-1:0]  size_log,
    output logic             first,
    output logic             is_final
);
    localparam int IW = OFF_W + 1;

    logic [LEN_W-1:0] remaining;
    logic [IW-1:0]    step_bytes;
    logic [IW-1:0]    next_off;

    always_comb begin
        step_bytes = IW'(1) << size_log;
        next_off   = ({1'b0, offset} & ~(step_bytes - IW'(1))) + step_bytes;
        is_final   = (remaining == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset    <= '0;
            size_log  <= '0;
            remaining <= '0;
            first     <= 1'b0;
        end else if (load) begin
            offset    <= ld_offset;
            size_log  <= ld_size_log;
            remaining <= ld_len;
            first     <= 1'b1;
        end else if (step) begin
            offset    <= next_off[OFF_W-1:0];
            remaining <= remaining - LEN_W'(1);
            first     <= 1'b0;
        end
    end
endmodule

// File: rtl/wstrb_burst_gen.sv
module wstrb_burst_gen
    import wsg_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int LEN_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    input  logic [$clog2(BUS_BYTES)-1:0] cmd_addr_lo,
    input  logic [2:0]                   cmd_size,
    input  logic [LEN_W-1:0]             cmd_len,
    output logic                         beat_valid,
    input  logic                         beat_ready,
    output logic [BUS_BYTES-1:0]         beat_strb,
    output logic                         beat_last
);
    localparam int OFF_W  = $clog2(BUS_BYTES);
    localparam int SZ_W   = 3;
    localparam int MAX_SZ = OFF_W;

    wsg_state_e      state, state_nxt;
    logic            load, step, beat_fire;
    logic [SZ_W-1:0] size_clamped;
    logic [OFF_W-1:0] cur_off;
    logic [SZ_W-1:0] cur_size;
    logic            cur_first, cur_final;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (cmd_valid)                state_nxt = ST_BEAT;
            ST_BEAT: if (beat_ready && cur_final)  state_nxt = ST_IDLE;
            default:                               state_nxt = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        cmd_ready  = (state == ST_IDLE);
        beat_valid = (state == ST_BEAT);
        beat_fire  = beat_valid && beat_ready;
        load       = cmd_valid && cmd_ready;
        step       = beat_fire && !cur_final;
        beat_last  = beat_valid && cur_final;
        size_clamped = (cmd_size > SZ_W'(MAX_SZ)) ? SZ_W'(MAX_SZ) : cmd_size;
    end

    wsg_track #(.OFF_W(OFF_W), .SZ_W(SZ_W), .LEN_W(LEN_W)) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .ld_offset  (cmd_addr_lo),
        .ld_size_log(size_clamped),
        .ld_len     (cmd_len),
        .offset     (cur_off),
        .size_log   (cur_size),
        .first      (cur_first),
        .is_final   (cur_final)
    );

    wsg_lane_mask #(.BUS_BYTES(BUS_BYTES), .OFF_W(OFF_W), .SZ_W(SZ_W)) mask_i (
        .offset  (cur_off),
        .size_log(cur_size),
        .first   (cur_first),
        .strb    (beat_strb)
    );

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_strb) && $stable(beat_last)));

    // R9
    strb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_strb != '0));

    // R3
    first_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=>
            (beat_valid && ((beat_strb & ((BUS_BYTES'(1) << $past(cmd_addr_lo)) - BUS_BYTES'(1))) == '0)));

    // R4
    full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !cur_first) |-> ($countones(beat_strb) == (32'd1 << cur_size)));

    // R6
    return_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && beat_last) |=> (cmd_ready && !beat_valid));
endmodule

// File: tb/wstrb_burst_gen_tb_top.sv
module wstrb_burst_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_addr_lo = '0;
    logic [2:0] cmd_size = '0;
    logic [7:0] cmd_len = '0;
    logic       beat_valid;
    logic       beat_ready = 1'b0;
    logic [3:0] beat_strb;
    logic       beat_last;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    wstrb_burst_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr_lo(cmd_addr_lo), .cmd_size(cmd_size), .cmd_len(cmd_len),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_strb(beat_strb), .beat_last(beat_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_burst(input int sz, input int off, input int len, input bit busy_cmd);
        int nbytes, cur, base, m;
        nbytes = 1 << ((sz > 2) ? 2 : sz);
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R2 ready before command", int'(cmd_ready), 1);
        cmd_valid   = 1'b1;
        cmd_addr_lo = 2'(off);
        cmd_size    = 3'(sz);
        cmd_len     = 8'(len);
        @(negedge clk);
        cmd_valid = busy_cmd;
        if (busy_cmd) begin
            cmd_addr_lo = 2'(off ^ 3);
            cmd_size    = 3'(sz ^ 1);
            cmd_len     = 8'(len + 7);
        end
        chk(beat_valid == 1'b1, "R2 beat valid after accept", int'(beat_valid), 1);
        cur = off;
        for (int b = 0; b <= len; b++) begin
            base = cur & ~(nbytes - 1);
            m = (((1 << nbytes) - 1) << base) & 15;
            if (b == 0) m = m & ((15 << cur) & 15);
            chk(int'(beat_strb) == m, (b == 0) ? "R3 first strobe" : "R4 later strobe",
                int'(beat_strb), m);
            chk(beat_strb != 4'h0, "R9 nonzero strobe", int'(beat_strb), m);
            chk(beat_last == (b == len), "R5 last flag", int'(beat_last), int'(b == len));
            chk(cmd_ready == 1'b0, "R6 busy", int'(cmd_ready), 0);
            if (((b + off + sz) % 3) == 1) begin
                beat_ready = 1'b0;
                @(negedge clk);
                chk(int'(beat_strb) == m && beat_valid, "R7 stall hold strobe", int'(beat_strb), m);
                chk(beat_last == (b == len), "R7 stall hold last", int'(beat_last), int'(b == len));
            end
            beat_ready = 1'b1;
            @(negedge clk);
            beat_ready = 1'b0;
            cur = (base + nbytes) % 4;
        end
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b1, "R6 ready after last beat", int'(cmd_ready), 1);
        chk(beat_valid == 1'b0, "R5 no extra beat", int'(beat_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 reset ready", int'(cmd_ready), 1);
        chk(beat_valid == 1'b0, "R1 reset valid", int'(beat_valid), 0);
        chk(beat_last == 1'b0, "R1 reset last", int'(beat_last), 0);
        // Sweep: size codes 0,1,2 and R8 codes 3,7; all offsets; 1..6 beats
        for (int si = 0; si < 5; si++) begin
            for (int off = 0; off < 4; off++) begin
                for (int len = 0; len < 6; len++) begin
                    run_burst((si == 4) ? 7 : si, off, len, ((off + len) % 2) == 1);
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule